// File: doc/BRIEF.md
# Serial Byte Transmitter with Queue and Status Flags

This block turns bytes written by a host into asynchronous serial frames. Each frame has a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and one or two high stop bits. Bytes wait in a small first-in first-out queue. A shift stage takes the oldest byte as soon as it is free, so frames follow each other with no gap. Bit timing comes from a one-cycle enable pulse at sixteen times the bit rate. Each bit stays on the line for sixteen of these pulses.

The host drives the block with a one-cycle command strobe. The commands turn the transmitter on or off, abort it, and begin or end a break. Two flags report progress. The ready flag means a write will be accepted. The empty flag means every accepted byte has been completely sent. When the transmitter is off, bytes already queued are still sent, but new writes are refused. An abort clears the queue, stops the current frame at once and returns the line to idle. A break holds the line low until it is ended or an abort arrives.

Top module: `uart_tx_core`

## Requirements
- R1: A frame is a 0 start bit, then N data bits LSB first with N = data_bits_i + 5, then a parity bit when parity_i is 1 (even: the data bits plus parity hold an even number of ones) or 2 (odd), with no parity bit for codes 0 and 3, then one stop bit at 1, or two when two_stop_i is 1. The format is taken when the byte leaves the queue.
- R2: After the asynchronous reset, txd_o is 1, tx_ready_o is 0 and tx_empty_o is 1.
- R3: Commands are sampled when cmd_valid_i is 1. Code 1 enables the transmitter and code 2 disables it. tx_ready_o equals (enabled and queue not full), and changes on the cycle after the command. An enable command with no accepted write in the same cycle sets tx_empty_o on the next cycle.
- R4: An accepted write clears tx_empty_o on the next cycle. tx_empty_o sets again on the cycle after the final stop bit of the last queued byte completes, provided the queue is empty. If a write is accepted on that same cycle, tx_empty_o stays 0.
- R5: txd_o is 1 whenever no frame is being sent and no break is active.
- R6: After a disable, the frame in progress and every queued byte are still sent in full. Writes while disabled are dropped.
- R7: Command code 3 aborts. On the next cycle txd_o is 1, the queue is empty, the transmitter is disabled, any break has ended and tx_empty_o is 1. No further frame is sent.
- R8: Command code 4 forces txd_o to 0 from the next cycle until command code 5 or code 3.
- R9: The queue holds 8 bytes, and the shift stage holds one more. A write while tx_ready_o is 0 is dropped.
- R10: Each bit lasts 16 pulses of tick16_i. The start bit begins on the cycle after the byte leaves the queue. The next queued byte starts on the cycle after the last stop bit ends, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to send |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code: 1 enable, 2 disable, 3 abort, 4 break on, 5 break off |
| data_bits_i | input | 2 | Data bit count minus 5 |
| parity_i | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| two_stop_i | input | 1 | Two stop bits when 1 |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| txd_o | output | 1 | Serial line |
| tx_ready_o | output | 1 | A write will be accepted |
| tx_empty_o | output | 1 | All accepted bytes fully sent |

## Verification
The empty flag can be told to set and to clear in the same cycle. This happens when the last stop bit of the final queued byte ends on the same clock edge that accepts a new write. The bench provokes it by counting clock cycles from the middle of the last stop bit and placing a write exactly on the edge where that bit ends. It then checks that tx_empty_o stays 0, and that the new frame's start bit begins on the next cycle with the correct contents.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ENABLE  = 3'd1,
    CMD_DISABLE = 3'd2,
    CMD_ABORT   = 3'd3,
    CMD_BRK_ON  = 3'd4,
    CMD_BRK_OFF = 3'd5
  } tx_cmd_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } parity_e;

  typedef struct packed {
    logic [1:0] len_code;
    parity_e    par;
    logic       two_stop;
  } tx_fmt_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           data_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           data_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_fmt_t           fmt_i,
  output logic              pop_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int TW      = $clog2(OSR);
  localparam int BW      = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] shift_q, frame_d;
  logic [TW-1:0]      tick_q;
  logic [BW-1:0]      bit_q, last_q, last_d;
  logic               bit_end, finish, start;

  // whole frame assembled at load time, then shifted out LSB first
  always_comb begin
    logic [BW-1:0]     nd, pos;
    logic [DATA_W-1:0] mask;
    logic              par_bit;
    nd   = BW'(5) + BW'(fmt_i.len_code);
    mask = '0;
    for (int i = 0; i < DATA_W; i++) if (i < int'(nd)) mask[i] = 1'b1;
    par_bit = ^(data_i & mask);
    if (fmt_i.par == PAR_ODD) par_bit = ~par_bit;
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) if (mask[i]) frame_d[i+1] = data_i[i];
    pos = nd + BW'(1);
    if (fmt_i.par == PAR_EVEN || fmt_i.par == PAR_ODD) begin
      frame_d[pos] = par_bit;
      pos          = pos + BW'(1);
    end
    last_d = pos + BW'(fmt_i.two_stop);
  end

  assign bit_end = busy_q && tick_i && (tick_q == TW'(OSR-1));
  assign finish  = bit_end && (bit_q == last_q);
  assign start   = (!busy_q || finish) && avail_i && !abort_i;
  assign pop_o   = start;
  assign done_o  = finish && !abort_i;
  assign busy_o  = busy_q;
  assign line_o  = busy_q ? shift_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
      last_q  <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      tick_q  <= '0;
      bit_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      shift_q <= frame_d;
      tick_q  <= '0;
      bit_q   <= '0;
      last_q  <= last_d;
    end else if (finish) begin
      busy_q  <= 1'b0;
      tick_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        tick_q  <= '0;
        bit_q   <= bit_q + BW'(1);
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
      end else begin
        tick_q  <= tick_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        data_bits_i,
  input  logic [1:0]        parity_i,
  input  logic              two_stop_i,
  input  logic              tick16_i,
  output logic              txd_o,
  output logic              tx_ready_o,
  output logic              tx_empty_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic              enabled_q, empty_q, brk_q;
  logic              is_en, is_dis, is_abort, is_brk_on, is_brk_off;
  logic              push, pop, done, busy, line;
  logic              fifo_empty, fifo_full;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     fifo_cnt;
  tx_fmt_t           fmt;
  tx_cmd_e           cmd;

  assign cmd        = tx_cmd_e'(cmd_i);
  assign is_en      = cmd_valid_i && (cmd == CMD_ENABLE);
  assign is_dis     = cmd_valid_i && (cmd == CMD_DISABLE);
  assign is_abort   = cmd_valid_i && (cmd == CMD_ABORT);
  assign is_brk_on  = cmd_valid_i && (cmd == CMD_BRK_ON);
  assign is_brk_off = cmd_valid_i && (cmd == CMD_BRK_OFF);

  assign fmt  = '{len_code: data_bits_i, par: parity_e'(parity_i), two_stop: two_stop_i};
  assign push = wr_i && enabled_q && !fifo_full && !is_abort;

  uart_tx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (is_abort),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (is_abort),
    .tick_i  (tick16_i),
    .avail_i (!fifo_empty),
    .data_i  (head),
    .fmt_i   (fmt),
    .pop_o   (pop),
    .done_o  (done),
    .busy_o  (busy),
    .line_o  (line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enabled_q <= 1'b0;
      empty_q   <= 1'b1;
      brk_q     <= 1'b0;
    end else if (is_abort) begin
      enabled_q <= 1'b0;
      empty_q   <= 1'b1;
      brk_q     <= 1'b0;
    end else begin
      if (is_en)           enabled_q <= 1'b1;
      else if (is_dis)     enabled_q <= 1'b0;
      if (is_brk_on)       brk_q <= 1'b1;
      else if (is_brk_off) brk_q <= 1'b0;
      // an accepted write outranks both set conditions
      if (push)                    empty_q <= 1'b0;
      else if (is_en)              empty_q <= 1'b1;
      else if (done && fifo_empty) empty_q <= 1'b1;
    end
  end

  assign txd_o      = brk_q ? 1'b0 : line;
  assign tx_ready_o = enabled_q && !fifo_full;
  assign tx_empty_o = empty_q;
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int DEPTH = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_i,
  input logic                       cmd_valid_i,
  input logic [2:0]                 cmd_i,
  input logic                       tick16_i,
  input logic                       txd_o,
  input logic                       tx_ready_o,
  input logic                       tx_empty_o,
  input logic                       busy_i,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= ($clog2(DEPTH+1))'(DEPTH)) else $error("queue overflow"); // R9

  AST_FULL_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i == ($clog2(DEPTH+1))'(DEPTH)) |-> !tx_ready_o) else $error("ready while full"); // R9

  AST_DISABLE_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd2) |=> !tx_ready_o) else $error("ready after disable"); // R3

  AST_ENABLE_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd1 && !wr_i) |=> tx_empty_o) else $error("empty not set"); // R3

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_ready_o && !cmd_valid_i) |=> !tx_empty_o) else $error("empty not cleared"); // R4

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd3) |=> (txd_o && tx_empty_o && !tx_ready_o && !busy_i)) else $error("abort"); // R7

  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd4) |=> !txd_o) else $error("break not low"); // R8

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick16_i && !cmd_valid_i) |=> $stable(txd_o)) else $error("bit moved"); // R10
endmodule

bind uart_tx_core uart_tx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .tick16_i    (tick16_i),
  .txd_o       (txd_o),
  .tx_ready_o  (tx_ready_o),
  .tx_empty_o  (tx_empty_o),
  .busy_i      (busy),
  .fifo_cnt_i  (fifo_cnt)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [2:0] C_EN = 3'd1, C_DIS = 3'd2, C_ABT = 3'd3, C_BON = 3'd4, C_BOFF = 3'd5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, cmd_v = 1'b0, two = 1'b0, tick = 1'b1;
  logic [7:0] wdat = '0;
  logic [2:0] cmd = '0;
  logic [1:0] dbits = 2'd3, par = 2'd0;
  logic       txd, rdy, emp;
  int         vectors = 0, miscompares = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdat),
    .cmd_valid_i(cmd_v), .cmd_i(cmd), .data_bits_i(dbits), .parity_i(par),
    .two_stop_i(two), .tick16_i(tick), .txd_o(txd), .tx_ready_o(rdy), .tx_empty_o(emp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] c, input logic [1:0] p, input logic t);
    return 1 + 5 + int'(c) + ((p == 2'd1 || p == 2'd2) ? 1 : 0) + 1 + int'(t);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] c,
                                            input logic [1:0] p);
    logic [11:0] b = '1;
    int nd = 5 + int'(c);
    logic pb = 1'b0;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[1+i] = d[i];
      pb = pb ^ d[i];
    end
    if (p == 2'd1) b[1+nd] = pb;
    if (p == 2'd2) b[1+nd] = ~pb;
    return b;
  endfunction

  task automatic do_cmd(input logic [2:0] c);
    cmd_v = 1'b1; cmd = c;
    @(negedge clk);
    cmd_v = 1'b0; cmd = '0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr = 1'b1; wdat = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // n=0 is the first negedge showing the start bit; bit k sampled at n = 8 + 16k
  task automatic capture(input int len, output logic [11:0] bits, output int waited);
    bits = '1; waited = 0;
    while (txd !== 1'b0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    repeat (8) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < len; k++) begin
      repeat (16) @(negedge clk);
      bits[k] = txd;
    end
  endtask

  task automatic hold_level(input string req, input logic lvl, input int n);
    logic bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== lvl) bad = 1'b1;
    end
    chk(req, bad, 1'b0);
  endtask

  task automatic send_check(input string req, input logic [7:0] d);
    logic [11:0] got;
    int w;
    int len = exp_len(dbits, par, two);
    write_byte(d);
    capture(len, got, w);
    chk(req, got, exp_frame(d, dbits, par));
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    $display("FAIL watchdog: actual timeout expected completion");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [11:0] got;
    int w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 txd", txd, 1'b1);
    chk("R2 ready", rdy, 1'b0);
    chk("R2 empty", emp, 1'b1);

    // writes while disabled are dropped, line stays idle
    write_byte(8'h55);
    chk("R6 write ignored empty", emp, 1'b1);
    hold_level("R5 idle high", 1'b1, 40);

    do_cmd(C_EN);
    chk("R3 ready on enable", rdy, 1'b1);
    chk("R3 empty on enable", emp, 1'b1);

    // 8N1 frame, exact timing
    dbits = 2'd3; par = 2'd0; two = 1'b0;
    write_byte(8'hA5);
    chk("R4 write clears empty", emp, 1'b0);
    capture(10, got, w);
    chk("R10 start one cycle after load", w, 1);
    chk("R1 8N1 frame", got, exp_frame(8'hA5, 2'd3, 2'd0));
    repeat (7) @(negedge clk);
    chk("R4 empty low during last stop", emp, 1'b0);
    @(negedge clk);
    chk("R4 empty after last stop", emp, 1'b1);
    chk("R5 line high after frame", txd, 1'b1);

    // random formats and data
    for (int it = 0; it < 16; it++) begin
      dbits = 2'($urandom % 4);
      par   = 2'($urandom % 4);
      two   = 1'($urandom % 2);
      send_check("R1 random frame", 8'($urandom));
      chk("R4 empty after random frame", emp, 1'b1);
    end

    // back-to-back frames, no gap, then write landing on the finishing edge
    dbits = 2'd2; par = 2'd1; two = 1'b1;
    fork
      begin
        write_byte(8'h31); write_byte(8'h4E); write_byte(8'h7F);
      end
      begin
        capture(11, got, w);
        chk("R1 b2b frame 0", got, exp_frame(8'h31, 2'd2, 2'd1));
        chk("R10 first start", w, 2);
        capture(11, got, w);
        chk("R1 b2b frame 1", got, exp_frame(8'h4E, 2'd2, 2'd1));
        chk("R10 no gap 1", w, 8);
        capture(11, got, w);
        chk("R1 b2b frame 2", got, exp_frame(8'h7F, 2'd2, 2'd1));
        chk("R10 no gap 2", w, 8);
      end
    join
    repeat (7) @(negedge clk);
    write_byte(8'h3C);
    chk("R4 write on finish edge keeps empty low", emp, 1'b0);
    capture(11, got, w);
    chk("R10 start after coincident write", w, 1);
    chk("R1 coincident frame", got, exp_frame(8'h3C, 2'd2, 2'd1));
    repeat (8) @(negedge clk);
    chk("R4 empty after coincident frame", emp, 1'b1);

    // fill: 8 in queue plus 1 in shifter, tenth dropped
    dbits = 2'd3; par = 2'd0; two = 1'b0;
    tick = 1'b0;
    for (int i = 0; i < 10; i++) begin
      write_byte(8'h10 + 8'(i));
      if (i == 7) chk("R9 ready after 8 writes", rdy, 1'b1);
      if (i == 8) chk("R9 full after 9 writes", rdy, 1'b0);
    end
    tick = 1'b1;
    for (int i = 0; i < 9; i++) begin
      capture(10, got, w);
      chk("R9 queued frame", got, exp_frame(8'h10 + 8'(i), 2'd3, 2'd0));
    end
    repeat (8) @(negedge clk);
    chk("R9 empty after drain", emp, 1'b1);
    hold_level("R9 dropped byte not sent", 1'b1, 60);

    // disable still drains, refuses writes
    tick = 1'b0;
    write_byte(8'hC3); write_byte(8'h96);
    do_cmd(C_DIS);
    chk("R3 ready low after disable", rdy, 1'b0);
    write_byte(8'hEE);
    tick = 1'b1;
    capture(10, got, w);
    chk("R6 drain frame 0", got, exp_frame(8'hC3, 2'd3, 2'd0));
    capture(10, got, w);
    chk("R6 drain frame 1", got, exp_frame(8'h96, 2'd3, 2'd0));
    repeat (8) @(negedge clk);
    chk("R6 empty after drain", emp, 1'b1);
    hold_level("R6 refused byte not sent", 1'b1, 60);

    // re-enable sets empty while data pending, then abort flushes
    do_cmd(C_EN);
    tick = 1'b0;
    write_byte(8'h01); write_byte(8'h02); write_byte(8'h03);
    chk("R4 pending clears empty", emp, 1'b0);
    do_cmd(C_DIS);
    do_cmd(C_EN);
    chk("R3 re-enable sets empty", emp, 1'b1);
    chk("R3 frame still pending", txd, 1'b0);
    do_cmd(C_ABT);
    chk("R7 line idle", txd, 1'b1);
    chk("R7 empty", emp, 1'b1);
    chk("R7 disabled", rdy, 1'b0);
    tick = 1'b1;
    hold_level("R7 queue flushed", 1'b1, 200);

    // break on/off, and abort ending a break
    do_cmd(C_EN);
    do_cmd(C_BON);
    chk("R8 break low", txd, 1'b0);
    hold_level("R8 break held", 1'b0, 50);
    do_cmd(C_BOFF);
    chk("R8 break released", txd, 1'b1);
    do_cmd(C_BON);
    do_cmd(C_ABT);
    chk("R8 abort ends break", txd, 1'b1);
    do_cmd(C_EN);
    dbits = 2'd0; par = 2'd2; two = 1'b1;
    send_check("R1 5O2 after break", 8'h1B);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule